// File: doc/BRIEF.md
# SRAM Power and Mode Sequencer

This block sits between a host's request port and the command pins of a late-write synchronous SRAM. The host asks for reads, writes, sleep entry or exit, and changes of the memory's mode pin, each through a valid/ready handshake. The sequencer turns every accepted read or write into one command cycle on the select and write-enable pins. Every other cycle is a deselect.

The sequencer also enforces the memory's timing rules by holding ready low and padding with deselects. Reads are refused until the output-driver calibration window after reset has run out. A write may not directly follow a read. Two deselects are inserted before the sleep pin rises or the mode pin changes. The sleep pin is held for a minimum enable time. After the sleep pin falls, or after the mode pin changes, a recovery run of deselects follows before any new read or write.

Top module: `sram_seq`

## Requirements
- R1: While reset is held, the outputs are sram_sel_n=1, sram_we_n=1, sram_sleep=0 and sram_mode=MODE_INIT (default 1).
- R2: Requests are coded on req_op as 00 read, 01 write, 10 sleep control and 11 mode set. An accepted read shows sel_n=0 and we_n=1 in the cycle after acceptance. An accepted write shows sel_n=0 and we_n=0 in that cycle. Every cycle without an accepted read or write shows sel_n=1 and we_n=1.
- R3: A read is not accepted until PWRUP_CYC clock edges after reset release have passed, so the earliest read appears after edge PWRUP_CYC+1. Writes are accepted during that window.
- R4: While the current output cycle is a read, a write request sees ready low, so at least one deselect cycle separates a read from a following write.
- R5: An accepted sleep-enter request (op 10, req_arg=1) issues SLEEP_PRE_DSEL deselect cycles (default 2) and then raises sram_sleep. No read or write is issued while sram_sleep is high.
- R6: Once raised, sram_sleep stays high for at least ZZE_CYC cycles, and ready stays low during that time. While asleep, only a sleep-exit request (op 10, req_arg=0) is accepted.
- R7: An accepted sleep-exit request lowers sram_sleep in the next cycle. Ready then stays low, and only deselects are issued, for ZZR_CYC cycles.
- R8: A mode request (op 11) issues MODE_PRE_DSEL deselect cycles (default 2) and then drives sram_mode to req_arg. Ready then stays low, and only deselects are issued, for MODE_POST_DSEL cycles (default 32).
- R9: A sleep-exit request while awake is accepted and has no effect: outputs stay deselected and awake, and ready stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_op | input | 2 | Request kind: 00 read, 01 write, 10 sleep control, 11 mode set |
| req_arg | input | 1 | For sleep control, 1 enters and 0 leaves; for mode set, the new mode value |
| req_ready | output | 1 | Request can be accepted this cycle |
| sram_sel_n | output | 1 | Memory select, active low |
| sram_we_n | output | 1 | Memory write enable, active low |
| sram_sleep | output | 1 | Memory sleep pin |
| sram_mode | output | 1 | Memory mode pin |

## Verification
The bench builds the sequencer with PWRUP_CYC=64, ZZE_CYC=5 and ZZR_CYC=6, and keeps the two-deselect pre-padding and the 32-deselect mode recovery at their defaults. The short calibration window lets a read that is held pending from the first cycles be accepted at exactly the edge the rule allows. The distinct enable and recovery counts make an off-by-one in either sleep phase show up as a one-cycle shift in ready or in the sleep pin.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

    typedef enum logic [1:0] {
        OP_RD   = 2'b00,
        OP_WR   = 2'b01,
        OP_SLP  = 2'b10,
        OP_MODE = 2'b11
    } req_op_e;

    // Command encoding on the pins as {sel_n, we_n}
    typedef enum logic [1:0] {
        CMD_WR   = 2'b00,
        CMD_RD   = 2'b01,
        CMD_DSEL = 2'b11
    } cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SLP_PRE,
        ST_SLP_HOLD,
        ST_ASLEEP,
        ST_WAKE,
        ST_MODE_PRE,
        ST_MODE_POST
    } seq_st_e;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_seq_pwrup.sv
module sram_seq_pwrup #(
    parameter int LIMIT = 8192
) (
    input  logic clk,
    input  logic rst_n,
    output logic done
);
    localparam int W = $clog2(LIMIT + 1);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (cnt_q != W'(LIMIT)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign done = (cnt_q == W'(LIMIT));
endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
    import sram_seq_pkg::*;
#(
    parameter int   SLEEP_PRE_DSEL = 2,
    parameter int   ZZE_CYC        = 3,
    parameter int   ZZR_CYC        = 4,
    parameter int   MODE_PRE_DSEL  = 2,
    parameter int   MODE_POST_DSEL = 32,
    parameter logic MODE_INIT      = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwr_done,
    input  logic       req_valid,
    input  logic [1:0] req_op,
    input  logic       req_arg,
    output logic       req_ready,
    output logic       sel_n,
    output logic       we_n,
    output logic       sleep,
    output logic       mode
);
    localparam int MAXC = max2(max2(max2(SLEEP_PRE_DSEL, ZZE_CYC), max2(ZZR_CYC, MODE_PRE_DSEL)),
                               MODE_POST_DSEL);
    localparam int CW   = $clog2(MAXC + 1);

    typedef struct packed {
        seq_st_e       st;
        logic [CW-1:0] cnt;
        cmd_e          cmd;
        logic          sleep;
        logic          mode;
        logic          mode_pend;
    } seq_state_t;

    seq_state_t cur_q, nxt_d;
    req_op_e    op;
    logic       rdy;
    logic       take;
    logic       cnt_zero;

    assign op       = req_op_e'(req_op);
    assign cnt_zero = (cur_q.cnt == '0);

    always_comb begin
        nxt_d = cur_q;
        nxt_d.cmd = CMD_DSEL;
        rdy = 1'b0;
        take = 1'b0;
        unique case (cur_q.st)
            ST_IDLE: begin
                case (op)
                    OP_RD:   rdy = pwr_done;
                    OP_WR:   rdy = (cur_q.cmd != CMD_RD);
                    default: rdy = 1'b1;
                endcase
                take = req_valid && rdy;
                if (take) begin
                    case (op)
                        OP_RD: nxt_d.cmd = CMD_RD;
                        OP_WR: nxt_d.cmd = CMD_WR;
                        OP_SLP: begin
                            if (req_arg) begin
                                nxt_d.st  = ST_SLP_PRE;
                                nxt_d.cnt = CW'(SLEEP_PRE_DSEL - 1);
                            end
                        end
                        default: begin
                            nxt_d.st        = ST_MODE_PRE;
                            nxt_d.cnt       = CW'(MODE_PRE_DSEL - 1);
                            nxt_d.mode_pend = req_arg;
                        end
                    endcase
                end
            end
            ST_SLP_PRE: begin
                if (cnt_zero) begin
                    nxt_d.st    = ST_SLP_HOLD;
                    nxt_d.sleep = 1'b1;
                    nxt_d.cnt   = CW'(ZZE_CYC - 1);
                end else begin
                    nxt_d.cnt = cur_q.cnt - 1'b1;
                end
            end
            ST_SLP_HOLD: begin
                if (cnt_zero) begin
                    nxt_d.st = ST_ASLEEP;
                end else begin
                    nxt_d.cnt = cur_q.cnt - 1'b1;
                end
            end
            ST_ASLEEP: begin
                rdy  = (op == OP_SLP) && !req_arg;
                take = req_valid && rdy;
                if (take) begin
                    nxt_d.st    = ST_WAKE;
                    nxt_d.sleep = 1'b0;
                    nxt_d.cnt   = CW'(ZZR_CYC - 1);
                end
            end
            ST_WAKE: begin
                if (cnt_zero) begin
                    nxt_d.st = ST_IDLE;
                end else begin
                    nxt_d.cnt = cur_q.cnt - 1'b1;
                end
            end
            ST_MODE_PRE: begin
                if (cnt_zero) begin
                    nxt_d.st   = ST_MODE_POST;
                    nxt_d.mode = cur_q.mode_pend;
                    nxt_d.cnt  = CW'(MODE_POST_DSEL - 1);
                end else begin
                    nxt_d.cnt = cur_q.cnt - 1'b1;
                end
            end
            ST_MODE_POST: begin
                if (cnt_zero) begin
                    nxt_d.st = ST_IDLE;
                end else begin
                    nxt_d.cnt = cur_q.cnt - 1'b1;
                end
            end
            default: nxt_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q.st        <= ST_IDLE;
            cur_q.cnt       <= '0;
            cur_q.cmd       <= CMD_DSEL;
            cur_q.sleep     <= 1'b0;
            cur_q.mode      <= MODE_INIT;
            cur_q.mode_pend <= MODE_INIT;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign req_ready = rdy;
    assign sel_n     = cur_q.cmd[1];
    assign we_n      = cur_q.cmd[0];
    assign sleep     = cur_q.sleep;
    assign mode      = cur_q.mode;
endmodule

// File: rtl/sram_seq.sv
module sram_seq #(
    parameter int   PWRUP_CYC      = 8192,
    parameter int   SLEEP_PRE_DSEL = 2,
    parameter int   ZZE_CYC        = 3,
    parameter int   ZZR_CYC        = 4,
    parameter int   MODE_PRE_DSEL  = 2,
    parameter int   MODE_POST_DSEL = 32,
    parameter logic MODE_INIT      = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic [1:0] req_op,
    input  logic       req_arg,
    output logic       req_ready,
    output logic       sram_sel_n,
    output logic       sram_we_n,
    output logic       sram_sleep,
    output logic       sram_mode
);
    logic pwr_done;

    sram_seq_pwrup #(
        .LIMIT(PWRUP_CYC)
    ) u_pwrup (
        .clk  (clk),
        .rst_n(rst_n),
        .done (pwr_done)
    );

    sram_seq_ctrl #(
        .SLEEP_PRE_DSEL(SLEEP_PRE_DSEL),
        .ZZE_CYC       (ZZE_CYC),
        .ZZR_CYC       (ZZR_CYC),
        .MODE_PRE_DSEL (MODE_PRE_DSEL),
        .MODE_POST_DSEL(MODE_POST_DSEL),
        .MODE_INIT     (MODE_INIT)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwr_done (pwr_done),
        .req_valid(req_valid),
        .req_op   (req_op),
        .req_arg  (req_arg),
        .req_ready(req_ready),
        .sel_n    (sram_sel_n),
        .we_n     (sram_we_n),
        .sleep    (sram_sleep),
        .mode     (sram_mode)
    );
endmodule

// File: rtl/sram_seq_chk.sv
module sram_seq_chk #(
    parameter int PWRUP_CYC      = 8192,
    parameter int ZZE_CYC        = 3,
    parameter int ZZR_CYC        = 4,
    parameter int MODE_POST_DSEL = 32
) (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic [1:0] req_op,
    input logic       req_ready,
    input logic       sel_n,
    input logic       we_n,
    input logic       sleep,
    input logic       mode
);
    localparam int PW = $clog2(PWRUP_CYC + 1);
    localparam int HW = $clog2(ZZE_CYC + 1);
    localparam int RW = $clog2(ZZR_CYC + 1);
    localparam int MW = $clog2(MODE_POST_DSEL + 1);

    logic [PW-1:0] since_rst;
    logic [HW-1:0] hold_cnt;
    logic [RW-1:0] wake_cnt;
    logic [MW-1:0] mode_cnt;
    logic          sleep_prev;
    logic          mode_prev;
    logic          rw_take;

    assign rw_take = req_valid && req_ready && !req_op[1];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_rst  <= '0;
            hold_cnt   <= '0;
            wake_cnt   <= RW'(ZZR_CYC);
            mode_cnt   <= MW'(MODE_POST_DSEL);
            sleep_prev <= 1'b0;
            mode_prev  <= mode;
        end else begin
            sleep_prev <= sleep;
            mode_prev  <= mode;
            if (since_rst != PW'(PWRUP_CYC)) since_rst <= since_rst + 1'b1;
            if (!sleep) hold_cnt <= '0;
            else if (hold_cnt != HW'(ZZE_CYC)) hold_cnt <= hold_cnt + 1'b1;
            if (sleep_prev && !sleep) wake_cnt <= RW'(1);
            else if (sel_n && wake_cnt != RW'(ZZR_CYC)) wake_cnt <= wake_cnt + 1'b1;
            if (mode != mode_prev) mode_cnt <= MW'(1);
            else if (sel_n && mode_cnt != MW'(MODE_POST_DSEL)) mode_cnt <= mode_cnt + 1'b1;
        end
    end

    AST_RD_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_op == 2'b00) |=> (!sel_n && we_n)); // R2
    AST_WR_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_op == 2'b01) |=> (!sel_n && !we_n)); // R2
    AST_IDLE_DSEL: assert property (@(posedge clk) disable iff (!rst_n)
        !rw_take |=> (sel_n && we_n)); // R2
    AST_PWRUP_RD: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n && we_n) |-> (since_rst == PW'(PWRUP_CYC))); // R3
    AST_TURNAROUND: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n && !we_n) |-> !$past(!sel_n && we_n)); // R4
    AST_SLEEP_PRE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sleep) |-> ($past(sel_n) && $past(sel_n, 2))); // R5
    AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> sel_n); // R5
    AST_SLEEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_prev && !sleep) |-> (hold_cnt == HW'(ZZE_CYC))); // R6
    AST_WAKE_REC: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_n |-> (wake_cnt == RW'(ZZR_CYC))); // R7
    AST_MODE_PRE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mode) |-> ($past(sel_n) && $past(sel_n, 2))); // R8
    AST_MODE_POST: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_n |-> (mode_cnt == MW'(MODE_POST_DSEL))); // R8
endmodule

bind sram_seq sram_seq_chk #(
    .PWRUP_CYC     (PWRUP_CYC),
    .ZZE_CYC       (ZZE_CYC),
    .ZZR_CYC       (ZZR_CYC),
    .MODE_POST_DSEL(MODE_POST_DSEL)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_op   (req_op),
    .req_ready(req_ready),
    .sel_n    (sram_sel_n),
    .we_n     (sram_we_n),
    .sleep    (sram_sleep),
    .mode     (sram_mode)
);

// File: tb/tb_sram_seq.sv
`timescale 1ns/1ps
module tb_sram_seq;
    localparam int P     = 64;
    localparam int SPRE  = 2;
    localparam int ZZE   = 5;
    localparam int ZZR   = 6;
    localparam int MPRE  = 2;
    localparam int MPOST = 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] req_op = 2'b00;
    logic       req_arg = 1'b0;
    logic       req_ready, sram_sel_n, sram_we_n, sram_sleep, sram_mode;

    always #2.5 clk = ~clk;

    sram_seq #(
        .PWRUP_CYC(P), .SLEEP_PRE_DSEL(SPRE), .ZZE_CYC(ZZE), .ZZR_CYC(ZZR),
        .MODE_PRE_DSEL(MPRE), .MODE_POST_DSEL(MPOST), .MODE_INIT(1'b1)
    ) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_arg(req_arg), .req_ready(req_ready), .sram_sel_n(sram_sel_n),
        .sram_we_n(sram_we_n), .sram_sleep(sram_sleep), .sram_mode(sram_mode)
    );

    int    n_chk = 0;
    int    n_fail = 0;
    bit    finished = 0;
    string tag = "R1";

    // behavioural reference: edge counter and event times
    int   n, idle_from, sleep_at, mode_at, first_rd;
    bit   asleep;
    logic mode_pend, e_sel, e_we, e_sleep, e_mode;

    function automatic logic m_ready(input logic [1:0] op, input logic arg);
        if (n < idle_from) return 1'b0;
        if (asleep) return (op == 2'b10) && !arg;
        case (op)
            2'b00:   return n >= P;
            2'b01:   return !(e_sel == 1'b0 && e_we == 1'b1);
            default: return 1'b1;
        endcase
    endfunction

    always @(posedge clk) begin
        logic acc, ns, nw;
        if (!rst_n) begin
            n = 0; idle_from = 0; sleep_at = -1; mode_at = -1; first_rd = -1;
            asleep = 0; mode_pend = 1'b1;
            e_sel = 1'b1; e_we = 1'b1; e_sleep = 1'b0; e_mode = 1'b1;
        end else begin
            acc = req_valid && m_ready(req_op, req_arg);
            ns = 1'b1; nw = 1'b1;
            if (acc) begin
                if (asleep) begin
                    asleep = 0; e_sleep = 1'b0; idle_from = n + 1 + ZZR;
                end else begin
                    case (req_op)
                        2'b00: begin ns = 1'b0; if (first_rd < 0) first_rd = n + 1; end
                        2'b01: begin ns = 1'b0; nw = 1'b0; end
                        2'b10: if (req_arg) begin
                            asleep = 1; sleep_at = n + 1 + SPRE; idle_from = n + 1 + SPRE + ZZE;
                        end
                        default: begin
                            mode_pend = req_arg; mode_at = n + 1 + MPRE;
                            idle_from = n + 1 + MPRE + MPOST;
                        end
                    endcase
                end
            end
            n = n + 1;
            e_sel = ns; e_we = nw;
            if (n == sleep_at) e_sleep = 1'b1;
            if (n == mode_at) e_mode = mode_pend;
        end
    end

    task automatic check(input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s at edge %0d: got %b expected %b", tag, what, n, act, exp);
        end
    endtask

    task automatic cyc(input logic v, input logic [1:0] op, input logic arg);
        @(negedge clk);
        check("sel_n", sram_sel_n, e_sel);
        check("we_n", sram_we_n, e_we);
        check("sleep", sram_sleep, e_sleep);
        check("mode", sram_mode, e_mode);
        req_valid = v; req_op = op; req_arg = arg;
        #1;
        if (v) check("ready", req_ready, m_ready(op, arg));
    endtask

    task automatic send(input logic [1:0] op, input logic arg);
        for (int i = 0; i < 300; i++) begin
            cyc(1'b1, op, arg);
            if (m_ready(op, arg)) break;
        end
    endtask

    task automatic idle(input int k);
        for (int i = 0; i < k; i++) cyc(1'b0, 2'b00, 1'b0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        tag = "R1";
        check("reset sel_n", sram_sel_n, 1'b1);
        check("reset we_n", sram_we_n, 1'b1);
        check("reset sleep", sram_sleep, 1'b0);
        check("reset mode", sram_mode, 1'b1);
        rst_n = 1'b1;

        tag = "R3";
        send(2'b01, 1'b0);
        send(2'b00, 1'b0);
        idle(1);
        n_chk++;
        if (first_rd != P + 1) begin
            n_fail++;
            $display("FAIL R3 first read edge: got %0d expected %0d", first_rd, P + 1);
        end

        tag = "R2";
        send(2'b01, 1'b0); send(2'b00, 1'b0); send(2'b00, 1'b0); send(2'b01, 1'b0);
        idle(2);

        tag = "R4";
        send(2'b00, 1'b0); send(2'b01, 1'b0); send(2'b00, 1'b0); send(2'b01, 1'b0);
        idle(2);

        tag = "R5";
        send(2'b01, 1'b0);
        send(2'b10, 1'b1);
        tag = "R6";
        for (int i = 0; i < ZZE + SPRE + 3; i++) cyc(1'b1, 2'b00, 1'b0);
        cyc(1'b1, 2'b11, 1'b0);
        tag = "R7";
        send(2'b10, 1'b0);
        send(2'b00, 1'b0);
        idle(2);

        tag = "R8";
        send(2'b11, 1'b0);
        send(2'b01, 1'b0);
        idle(1);
        send(2'b11, 1'b1);
        send(2'b00, 1'b0);
        idle(3);

        tag = "R9";
        send(2'b10, 1'b0);
        idle(3);
        send(2'b01, 1'b0);
        idle(3);
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL %s watchdog expired", tag);
        finish_run();
    end
endmodule